// File: doc/BRIEF.md
# Zero-Padded Channel Gram Matrix Unit

This block prepares the input of a singular value decomposition engine for a multi-antenna receiver. A real-valued channel matrix of any shape from 1×1 to 4×4 is written one element at a time into a fixed 4×4 store. On a start request, the block reads the store through a padding filter that forces every element outside the active rows and columns to zero. It then forms the positive semidefinite Gram product of the padded matrix.

The orientation of the product follows the shape. A tall or square matrix (rows ≥ columns) gives Hᵀ·H. A wide matrix gives H·Hᵀ. In both cases the result fits a 4×4 frame. The block also reports how many singular values are meaningful, which is the smaller of the two dimensions. One multiply-accumulate unit walks all sixteen result entries, four products each, so one fixed datapath serves all sixteen antenna configurations. The results stay readable through a combinational read port until the next run overwrites them.

Top module: `gram_frame_unit`

## Requirements
- R1: After reset, busy, done and errFlag are 0, rank is 0, and every one of the 16 result entries reads 0.
- R2: A pulse of loadEn writes loadVal into store position (loadRow, loadCol) when busy is 0. A load while busy is 1 leaves the store unchanged.
- R3: A start with rowCnt and colCnt both in 1..4, sampled while idle at clock edge E0, holds busy at 1 from E0 through E64. busy is 0 after E64. done is 1 for exactly the single cycle after E64, and the results are complete in that cycle.
- R4: Any stored element with row index ≥ rowCnt or column index ≥ colCnt enters the computation as zero, whatever value was loaded there.
- R5: When rowCnt ≥ colCnt, result entry (i, j) equals the sum over k = 0..3 of H[k][i]·H[k][j] on the padded matrix.
- R6: When rowCnt < colCnt, result entry (i, j) equals the sum over k = 0..3 of H[i][k]·H[j][k] on the padded matrix.
- R7: Elements are 16-bit two's complement. Each result is an exact 34-bit two's complement sum with no truncation. This includes the case of every operand being −32768, which gives 2^32.
- R8: An accepted start sets rank to min(rowCnt, colCnt) of that request.
- R9: A start while idle with rowCnt or colCnt outside 1..4 sets errFlag to 1 after that edge. It does not raise busy or done, and it leaves rank and the results unchanged. errFlag returns to 0 at the next accepted start.
- R10: A start while busy is ignored. The run in progress keeps its dimensions and still ends at E64.
- R11: resVal shows result entry (resRow, resCol) combinationally. While idle it does not change unless the read address changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Element write strobe |
| loadRow | input | 2 | Row index of the element written |
| loadCol | input | 2 | Column index of the element written |
| loadVal | input | 16 | Signed element value |
| start | input | 1 | Start request, sampled while idle |
| rowCnt | input | 3 | Active row count, valid 1..4 |
| colCnt | input | 3 | Active column count, valid 1..4 |
| resRow | input | 2 | Read row of the result |
| resCol | input | 2 | Read column of the result |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| errFlag | output | 1 | Last rejected start had invalid dimensions |
| rank | output | 3 | Number of meaningful singular values |
| resVal | output | 34 | Signed result entry at the read address |

## Verification
The bench raises start at a falling edge, so the request is taken at the next rising edge E0. It then samples at each falling edge that follows. busy must read 1 at the 64 samples after E0 through E64. The sample after E64 must show busy low and done high, and the next sample must show done low again. Every result and rank is compared only in that done cycle or later while idle, so all sixteen writes have landed. A rejected start is judged at the first falling edge after its edge, where errFlag must already be set. The samples after that confirm that busy never rises. Stimulus injected in the middle of a run, a second start and a stray load, is applied at fixed step counts and judged at the normal end of the original run.

// File: rtl/gram_pkg.sv
package gram_pkg;
  localparam int unsigned G_DIM    = 4;
  localparam int unsigned G_DATA_W = 16;
  localparam int unsigned G_IDX_W  = $clog2(G_DIM);
  localparam int unsigned G_CNT_W  = $clog2(G_DIM + 1);
  localparam int unsigned G_PROD_W = 2 * G_DATA_W;
  localparam int unsigned G_ACC_W  = G_PROD_W + G_IDX_W;
  localparam int unsigned G_STEP_W = 3 * G_IDX_W;
  localparam int unsigned G_ENT_W  = 2 * G_IDX_W;

  // strobes from control to datapath
  typedef struct packed {
    logic                capture;
    logic                mac;
    logic                first;
    logic                last;
    logic [G_IDX_W-1:0]  rowI;
    logic [G_IDX_W-1:0]  colJ;
    logic [G_IDX_W-1:0]  sumK;
  } gramStrobe_t;
endpackage

// File: rtl/gram_ctrl.sv
module gram_ctrl
  import gram_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [G_CNT_W-1:0] rowCnt,
  input  logic [G_CNT_W-1:0] colCnt,
  output logic               busy,
  output logic               done,
  output logic               errFlag,
  output gramStrobe_t        stb
);
  localparam logic [G_STEP_W-1:0] LAST_STEP = G_STEP_W'(G_DIM * G_DIM * G_DIM - 1);

  typedef enum logic {S_IDLE, S_RUN} ctrlState_t;

  ctrlState_t          state;
  logic [G_STEP_W-1:0] step;
  logic                cfgOk;
  logic                endStep;

  assign cfgOk = (rowCnt != '0) && (rowCnt <= G_CNT_W'(G_DIM)) &&
                 (colCnt != '0) && (colCnt <= G_CNT_W'(G_DIM));
  assign endStep = (step == LAST_STEP);
  assign busy    = (state == S_RUN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      step    <= '0;
      done    <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            if (cfgOk) begin
              state   <= S_RUN;
              step    <= '0;
              errFlag <= 1'b0;
            end else begin
              errFlag <= 1'b1;
            end
          end
        end
        S_RUN: begin
          step <= step + 1'b1;
          if (endStep) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.capture = (state == S_IDLE) && start && cfgOk;
    stb.mac     = busy;
    stb.sumK    = step[G_IDX_W-1:0];
    stb.colJ    = step[2*G_IDX_W-1:G_IDX_W];
    stb.rowI    = step[3*G_IDX_W-1:2*G_IDX_W];
    stb.first   = (stb.sumK == '0);
    stb.last    = (stb.sumK == G_IDX_W'(G_DIM - 1));
  end

  // R3: completion pulse lasts one cycle
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: done appears exactly when the run ends
  p_done_at_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R9: bad dimensions flag an error and do not start a run
  p_bad_cfg_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && !cfgOk) |=> (errFlag && !busy && !done));

  // R10: a running walk advances by one step regardless of start
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !endStep) |=> (busy && step == G_STEP_W'($past(step) + 1'b1)));
endmodule

// File: rtl/gram_dpath.sv
module gram_dpath
  import gram_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  gramStrobe_t                stb,
  input  logic                       busy,
  input  logic                       loadEn,
  input  logic [G_IDX_W-1:0]         loadRow,
  input  logic [G_IDX_W-1:0]         loadCol,
  input  logic signed [G_DATA_W-1:0] loadVal,
  input  logic [G_CNT_W-1:0]         rowCnt,
  input  logic [G_CNT_W-1:0]         colCnt,
  input  logic [G_IDX_W-1:0]         resRow,
  input  logic [G_IDX_W-1:0]         resCol,
  output logic [G_CNT_W-1:0]         rank,
  output logic signed [G_ACC_W-1:0]  resVal
);
  localparam int unsigned ENTRIES = G_DIM * G_DIM;

  logic signed [G_DATA_W-1:0] hMem [G_DIM][G_DIM];
  logic signed [G_ACC_W-1:0]  resQ [ENTRIES];
  logic [G_CNT_W-1:0]         nrQ, ntQ;
  logic                       tallQ;
  logic [G_IDX_W-1:0]         rA, cA, rB, cB;
  logic signed [G_DATA_W-1:0] opA, opB;
  logic signed [G_PROD_W-1:0] prod;
  logic signed [G_ACC_W-1:0]  prodExt, accQ, sumNow;
  logic [G_ENT_W-1:0]         entryIdx, readIdx;

  // element store, written only while idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < G_DIM; r++)
        for (int c = 0; c < G_DIM; c++)
          hMem[r][c] <= '0;
    end else if (loadEn && !busy) begin
      hMem[loadRow][loadCol] <= loadVal;
    end
  end

  // dimensions and orientation latched at an accepted start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nrQ   <= '0;
      ntQ   <= '0;
      tallQ <= 1'b0;
      rank  <= '0;
    end else if (stb.capture) begin
      nrQ   <= rowCnt;
      ntQ   <= colCnt;
      tallQ <= (rowCnt >= colCnt);
      rank  <= (rowCnt < colCnt) ? rowCnt : colCnt;
    end
  end

  // operand addressing: columns of H for a tall shape, rows for a wide one
  always_comb begin
    if (tallQ) begin
      rA = stb.sumK; cA = stb.rowI;
      rB = stb.sumK; cB = stb.colJ;
    end else begin
      rA = stb.rowI; cA = stb.sumK;
      rB = stb.colJ; cB = stb.sumK;
    end
    opA = (G_CNT_W'(rA) < nrQ && G_CNT_W'(cA) < ntQ) ? hMem[rA][cA] : '0;
    opB = (G_CNT_W'(rB) < nrQ && G_CNT_W'(cB) < ntQ) ? hMem[rB][cB] : '0;
  end

  assign prod    = opA * opB;
  assign prodExt = $signed({{(G_ACC_W - G_PROD_W){prod[G_PROD_W-1]}}, prod});
  assign sumNow  = (stb.first ? '0 : accQ) + prodExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        accQ <= '0;
    else if (stb.mac) accQ <= sumNow;
  end

  assign entryIdx = G_ENT_W'(int'(stb.rowI) * G_DIM + int'(stb.colJ));
  assign readIdx  = G_ENT_W'(int'(resRow) * G_DIM + int'(resCol));

  for (genvar e = 0; e < ENTRIES; e++) begin : g_res
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        resQ[e] <= '0;
      else if (stb.mac && stb.last && entryIdx == G_ENT_W'(e))
        resQ[e] <= sumNow;
    end
  end

  assign resVal = resQ[readIdx];
endmodule

// File: rtl/gram_frame_unit.sv
module gram_frame_unit
  import gram_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       loadEn,
  input  logic [G_IDX_W-1:0]         loadRow,
  input  logic [G_IDX_W-1:0]         loadCol,
  input  logic signed [G_DATA_W-1:0] loadVal,
  input  logic                       start,
  input  logic [G_CNT_W-1:0]         rowCnt,
  input  logic [G_CNT_W-1:0]         colCnt,
  input  logic [G_IDX_W-1:0]         resRow,
  input  logic [G_IDX_W-1:0]         resCol,
  output logic                       busy,
  output logic                       done,
  output logic                       errFlag,
  output logic [G_CNT_W-1:0]         rank,
  output logic signed [G_ACC_W-1:0]  resVal
);
  gramStrobe_t stb;

  gram_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .rowCnt  (rowCnt),
    .colCnt  (colCnt),
    .busy    (busy),
    .done    (done),
    .errFlag (errFlag),
    .stb     (stb)
  );

  gram_dpath i_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .busy    (busy),
    .loadEn  (loadEn),
    .loadRow (loadRow),
    .loadCol (loadCol),
    .loadVal (loadVal),
    .rowCnt  (rowCnt),
    .colCnt  (colCnt),
    .resRow  (resRow),
    .resCol  (resCol),
    .rank    (rank),
    .resVal  (resVal)
  );

  // R11: idle results hold unless the read address moves
  p_idle_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> ($stable(resVal) || !$stable(resRow) || !$stable(resCol)));
endmodule

// File: tb/test_gram_frame_unit.sv
module test_gram_frame_unit;
  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               loadEn = 1'b0;
  logic [1:0]         loadRow = '0, loadCol = '0;
  logic signed [15:0] loadVal = '0;
  logic               start = 1'b0;
  logic [2:0]         rowCnt = 3'd1, colCnt = 3'd1;
  logic [1:0]         resRow = '0, resCol = '0;
  logic               busy, done, errFlag;
  logic [2:0]         rank;
  logic signed [33:0] resVal;

  int checks = 0;
  int errs = 0;
  logic signed [15:0] hB [4][4];
  int lastNr = 0, lastNt = 0;

  always #10 clk = ~clk;

  gram_frame_unit i_gram_frame_unit (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadRow(loadRow), .loadCol(loadCol),
    .loadVal(loadVal), .start(start), .rowCnt(rowCnt), .colCnt(colCnt),
    .resRow(resRow), .resCol(resCol), .busy(busy), .done(done), .errFlag(errFlag),
    .rank(rank), .resVal(resVal)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint padB(int r, int c, int nr, int nt);
    if (r < nr && c < nt) return longint'(hB[r][c]);
    return 0;
  endfunction

  function automatic longint expEntry(int i, int j, int nr, int nt);
    longint s = 0;
    for (int k = 0; k < 4; k++) begin
      if (nr >= nt) s += padB(k, i, nr, nt) * padB(k, j, nr, nt);
      else          s += padB(i, k, nr, nt) * padB(j, k, nr, nt);
    end
    return s;
  endfunction

  task automatic writeElem(int r, int c, logic signed [15:0] v);
    @(negedge clk);
    loadEn = 1'b1; loadRow = 2'(r); loadCol = 2'(c); loadVal = v;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  function automatic logic signed [15:0] randVal();
    int sel = int'($urandom_range(0, 7));
    if (sel == 0) return 16'sh8000;
    if (sel == 1) return 16'sh7fff;
    return 16'($urandom);
  endfunction

  task automatic loadAll(bit extreme);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        hB[r][c] = extreme ? 16'sh8000 : randVal();
        writeElem(r, c, hB[r][c]);
      end
  endtask

  task automatic compareAll(int nr, int nt, string tag);
    string req;
    req = {(nr < 4 || nt < 4) ? "R4+" : "", (nr >= nt) ? "R5" : "R6"};
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        resRow = 2'(i); resCol = 2'(j);
        #1;
        check(longint'(resVal) == expEntry(i, j, nr, nt), req,
              $sformatf("%s %0dx%0d entry(%0d,%0d)", tag, nr, nt, i, j),
              longint'(resVal), expEntry(i, j, nr, nt));
      end
  endtask

  // full run with timing checks; inject adds a start and a load mid-run
  task automatic runCase(int nr, int nt, bit inject);
    int badBusy = 0;
    @(negedge clk);
    rowCnt = 3'(nr); colCnt = 3'(nt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= 64; c++) begin
      if (c > 1) @(negedge clk);
      if (!(busy && !done)) badBusy++;
      if (inject && c == 10) begin start = 1'b1; rowCnt = 3'd1; colCnt = 3'd1; end
      if (inject && c == 11) start = 1'b0;
      if (inject && c == 20) begin loadEn = 1'b1; loadRow = 2'd0; loadCol = 2'd0; loadVal = 16'sh7fff; end
      if (inject && c == 21) loadEn = 1'b0;
    end
    check(badBusy == 0, inject ? "R10" : "R3", "busy window E0..E64", badBusy, 0);
    @(negedge clk);
    check(!busy && done, inject ? "R10" : "R3", "end after E64 busy/done",
          {busy, done}, 2'b01);
    compareAll(nr, nt, inject ? "injected" : "run");
    check(rank == 3'((nr < nt) ? nr : nt), "R8", "rank", rank, (nr < nt) ? nr : nt);
    check(errFlag == 1'b0, "R9", "errFlag clear after accepted start", errFlag, 0);
    @(negedge clk);
    check(!done, "R3", "done single cycle", done, 0);
    lastNr = nr; lastNt = nt;
  endtask

  task automatic badCase(int nr, int nt);
    logic [2:0] rankBefore;
    int rose = 0;
    rankBefore = rank;
    @(negedge clk);
    rowCnt = 3'(nr); colCnt = 3'(nt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(errFlag == 1'b1, "R9", $sformatf("errFlag for %0dx%0d", nr, nt), errFlag, 1);
    for (int c = 0; c < 3; c++) begin
      if (busy || done) rose++;
      @(negedge clk);
    end
    check(rose == 0, "R9", "no run after bad dims", rose, 0);
    check(rank == rankBefore, "R9", "rank unchanged", rank, rankBefore);
    compareAll(lastNr, lastNt, "after bad start R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL R3 watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    logic signed [33:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!busy && !done && !errFlag, "R1", "flags after reset", {busy, done, errFlag}, 0);
    check(rank == 3'd0, "R1", "rank after reset", rank, 0);
    for (int i = 0; i < 16; i++) begin
      resRow = 2'(i / 4); resCol = 2'(i % 4);
      #1;
      check(resVal == 34'sd0, "R1", $sformatf("result %0d after reset", i), longint'(resVal), 0);
    end

    // R7: every operand at the negative extreme, entries equal 2^32
    loadAll(1'b1);
    runCase(4, 4, 1'b0);
    resRow = 2'd2; resCol = 2'd1; #1;
    check(longint'(resVal) == 64'sd4294967296, "R7", "extreme sum", longint'(resVal), 64'sd4294967296);

    // all sixteen shapes with junk in padded positions (R4, R5, R6, R8)
    for (int nr = 1; nr <= 4; nr++)
      for (int nt = 1; nt <= 4; nt++) begin
        loadAll(1'b0);
        runCase(nr, nt, (nr == 2 && nt == 3));
        if (nr == 2 && nt == 3) begin
          // R2: the mid-run load must not have reached the store
          runCase(nr, nt, 1'b0);
          resRow = 2'd0; resCol = 2'd0; #1;
          check(longint'(resVal) == expEntry(0, 0, 2, 3), "R2", "busy load ignored",
                longint'(resVal), expEntry(0, 0, 2, 3));
        end
      end

    // R2: idle loads do land
    hB[1][1] = 16'sd1000;
    writeElem(1, 1, hB[1][1]);
    runCase(4, 4, 1'b0);

    // R9: invalid dimensions
    badCase(0, 2);
    badCase(3, 5);
    badCase(7, 7);
    runCase(3, 1, 1'b0);

    // R11: idle read holds
    resRow = 2'd0; resCol = 2'd0; #1;
    held = resVal;
    repeat (5) @(negedge clk);
    check(resVal == held, "R11", "idle read stable", longint'(resVal), longint'(held));

    // random shapes and data
    for (int n = 0; n < 14; n++) begin
      loadAll(1'b0);
      runCase(int'($urandom_range(1, 4)), int'($urandom_range(1, 4)), 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule